// File: doc/BRIEF.md
# DRAM Row-Buffer Latency Controller

This block is a timing model of a multi-bank DRAM. It tracks which row each bank holds open and returns the number of cycles that one read or write request would take to service. Each request carries a physical address, a read/write flag and a page-policy select. The block maps the address to a bank and a row, works out whether the bank's row buffer hits, is empty or holds another row, and builds the latency from per-command costs. It also updates the bank's row-buffer entry as the selected policy requires. Separate running totals of access count and accumulated delay are kept for reads and for writes.

Address bits are split as follows, with the default parameters: bits [5:0] are the byte within a 64-byte cache block, bits [9:6] select the bank, bits [13:10] select the block within a 1024-byte row, and bits [31:14] form the row ID. Consecutive cache blocks therefore fall in consecutive banks. Data movement, refresh and command-bus scheduling are not modelled. One request may be accepted on every clock.

Top module: `dram_rowbuf_lat`

## Requirements
- R1: After reset `resp_valid` is 0, all four counters read 0, and every bank's row buffer is empty.
- R2: A request accepted on a rising edge (`req_valid` high) produces `resp_valid` high with its latency on `resp_lat` after that same edge, and `resp_valid` is low after any edge without a request; back-to-back requests each see the row-buffer state left by the one before.
- R3: The bank is (address / 64) mod 16 and the row ID is address / 16384; two addresses with the same bank and row ID but different low bits use the same row buffer.
- R4: With `req_policy` 2'b00 or 2'b11 (fixed), every access returns 100 cycles and no row-buffer entry changes.
- R5: With `req_policy` 2'b01 (open page), an access to the row already open in its bank returns 55 cycles (column access 45 + bus 10).
- R6: In open-page mode an access to an empty bank returns 100 cycles (activate 45 + column 45 + bus 10) and leaves the accessed row open.
- R7: In open-page mode an access to a bank holding a different row returns 145 cycles (precharge 45 + activate + column + bus) and leaves the new row open.
- R8: With `req_policy` 2'b10 (close page), every access returns 100 cycles and leaves the bank's row buffer empty.
- R9: Each read increments `rd_count` by one and adds its latency to `rd_delay`; writes leave both unchanged.
- R10: Each write increments `wr_count` by one and adds its latency to `wr_delay`; reads leave both unchanged.
- R11: An access changes only its own bank's row-buffer entry; rows open in other banks stay open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Physical byte address |
| req_policy | input | 2 | 00/11 fixed, 01 open page, 10 close page |
| resp_valid | output | 1 | Latency result valid (one cycle after request) |
| resp_lat | output | 8 | Service latency in cycles |
| rd_count | output | 32 | Number of reads serviced |
| wr_count | output | 32 | Number of writes serviced |
| rd_delay | output | 32 | Sum of read latencies |
| wr_delay | output | 32 | Sum of write latencies |

## Verification
A wrong row-buffer entry stays hidden until the next open-page access to that bank, which then reports 55, 100 or 145 where another value was due, so the bench revisits every bank with repeated, same-row and different-row addresses under mixed policies. A fixed or close access that corrupts an entry shows up one access later in the same bank, and a bank-select error shows as a hit or conflict in a bank that was never touched. Counter faults appear on the cycle after the request as a count or sum off by the latency of that access.

// File: rtl/dram_lat_pkg.sv
package dram_lat_pkg;

  typedef enum logic [1:0] {
    POL_FIXED     = 2'b00,
    POL_OPEN      = 2'b01,
    POL_CLOSE     = 2'b10,
    POL_FIXED_ALT = 2'b11
  } page_pol_e;

  typedef enum logic [1:0] {
    RB_EMPTY    = 2'b00,
    RB_HIT      = 2'b01,
    RB_CONFLICT = 2'b10
  } rb_state_e;

endpackage

// File: rtl/dram_bank_table.sv
module dram_bank_table
  import dram_lat_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 18,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [BANK_W-1:0] upd_bank,
  input  page_pol_e         upd_pol,
  input  logic [ROW_W-1:0]  upd_row,
  output logic              rd_valid,
  output logic [ROW_W-1:0]  rd_row
);

  logic [NUM_BANKS-1:0] valid_vec;
  logic [ROW_W-1:0]     row_vec [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             v_q, v_d;
    logic [ROW_W-1:0] r_q, r_d;
    logic             sel;

    assign sel = upd_en && (upd_bank == BANK_W'(b));

    always_comb begin
      v_d = v_q;
      r_d = r_q;
      if (sel) begin
        case (upd_pol)
          POL_OPEN: begin
            v_d = 1'b1;
            r_d = upd_row;
          end
          POL_CLOSE: v_d = 1'b0;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        r_q <= '0;
      end else if (sel) begin
        v_q <= v_d;
        r_q <= r_d;
      end
    end

    assign valid_vec[b] = v_q;
    assign row_vec[b]   = r_q;
  end

  assign rd_valid = valid_vec[upd_bank];
  assign rd_row   = row_vec[upd_bank];

endmodule

// File: rtl/dram_lat_calc.sv
module dram_lat_calc
  import dram_lat_pkg::*;
#(
  parameter int ROW_W   = 18,
  parameter int LAT_W   = 8,
  parameter int T_ACT   = 45,
  parameter int T_CAS   = 45,
  parameter int T_PRE   = 45,
  parameter int T_BUS   = 10,
  parameter int T_FIXED = 100
) (
  input  page_pol_e        pol,
  input  logic             bank_valid,
  input  logic [ROW_W-1:0] bank_row,
  input  logic [ROW_W-1:0] req_row,
  output logic [LAT_W-1:0] lat
);

  localparam int LAT_HIT   = T_CAS + T_BUS;
  localparam int LAT_EMPTY = T_ACT + T_CAS + T_BUS;
  localparam int LAT_CONF  = T_PRE + T_ACT + T_CAS + T_BUS;

  rb_state_e st;

  always_comb begin
    if (!bank_valid)             st = RB_EMPTY;
    else if (bank_row == req_row) st = RB_HIT;
    else                          st = RB_CONFLICT;
  end

  always_comb begin
    case (pol)
      POL_OPEN: begin
        case (st)
          RB_HIT:      lat = LAT_W'(LAT_HIT);
          RB_CONFLICT: lat = LAT_W'(LAT_CONF);
          default:     lat = LAT_W'(LAT_EMPTY);
        endcase
      end
      POL_CLOSE: lat = LAT_W'(LAT_EMPTY);
      default:   lat = LAT_W'(T_FIXED);
    endcase
  end

endmodule

// File: rtl/dram_stat_ctr.sv
module dram_stat_ctr #(
  parameter int LAT_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             is_write,
  input  logic [LAT_W-1:0] lat,
  output logic [CNT_W-1:0] rd_cnt,
  output logic [CNT_W-1:0] wr_cnt,
  output logic [CNT_W-1:0] rd_dly,
  output logic [CNT_W-1:0] wr_dly
);

  logic [CNT_W-1:0] rd_cnt_d, wr_cnt_d, rd_dly_d, wr_dly_d;

  always_comb begin
    rd_cnt_d = rd_cnt;
    wr_cnt_d = wr_cnt;
    rd_dly_d = rd_dly;
    wr_dly_d = wr_dly;
    if (is_write) begin
      wr_cnt_d = wr_cnt + CNT_W'(1);
      wr_dly_d = wr_dly + CNT_W'(lat);
    end else begin
      rd_cnt_d = rd_cnt + CNT_W'(1);
      rd_dly_d = rd_dly + CNT_W'(lat);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
      rd_dly <= '0;
      wr_dly <= '0;
    end else if (en) begin
      rd_cnt <= rd_cnt_d;
      wr_cnt <= wr_cnt_d;
      rd_dly <= rd_dly_d;
      wr_dly <= wr_dly_d;
    end
  end

endmodule

// File: rtl/dram_rowbuf_lat.sv
module dram_rowbuf_lat
  import dram_lat_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_BANKS   = 16,
  parameter int BLOCK_BYTES = 64,
  parameter int ROW_BYTES   = 1024,
  parameter int LAT_W       = 8,
  parameter int CNT_W       = 32,
  parameter int T_ACT       = 45,
  parameter int T_CAS       = 45,
  parameter int T_PRE       = 45,
  parameter int T_BUS       = 10,
  parameter int T_FIXED     = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_policy,
  output logic              resp_valid,
  output logic [LAT_W-1:0]  resp_lat,
  output logic [CNT_W-1:0]  rd_count,
  output logic [CNT_W-1:0]  wr_count,
  output logic [CNT_W-1:0]  rd_delay,
  output logic [CNT_W-1:0]  wr_delay
);

  localparam int BLK_SH = $clog2(BLOCK_BYTES);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_SH = $clog2(ROW_BYTES * NUM_BANKS);
  localparam int ROW_W  = ADDR_W - ROW_SH;

  page_pol_e        pol;
  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0]  row;
  logic              cur_valid;
  logic [ROW_W-1:0]  cur_row;
  logic [LAT_W-1:0]  lat_d;
  logic              resp_valid_d;
  logic [LAT_W-1:0]  resp_lat_d;

  assign pol  = page_pol_e'(req_policy);
  assign bank = req_addr[BLK_SH +: BANK_W];
  assign row  = req_addr[ADDR_W-1:ROW_SH];

  dram_bank_table #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (req_valid),
    .upd_bank(bank),
    .upd_pol (pol),
    .upd_row (row),
    .rd_valid(cur_valid),
    .rd_row  (cur_row)
  );

  dram_lat_calc #(
    .ROW_W  (ROW_W),
    .LAT_W  (LAT_W),
    .T_ACT  (T_ACT),
    .T_CAS  (T_CAS),
    .T_PRE  (T_PRE),
    .T_BUS  (T_BUS),
    .T_FIXED(T_FIXED)
  ) u_calc (
    .pol       (pol),
    .bank_valid(cur_valid),
    .bank_row  (cur_row),
    .req_row   (row),
    .lat       (lat_d)
  );

  dram_stat_ctr #(
    .LAT_W(LAT_W),
    .CNT_W(CNT_W)
  ) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (req_valid),
    .is_write(req_write),
    .lat     (lat_d),
    .rd_cnt  (rd_count),
    .wr_cnt  (wr_count),
    .rd_dly  (rd_delay),
    .wr_dly  (wr_delay)
  );

  always_comb begin
    resp_valid_d = req_valid;
    resp_lat_d   = resp_lat;
    if (req_valid) resp_lat_d = lat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_lat   <= '0;
    end else begin
      resp_valid <= resp_valid_d;
      resp_lat   <= resp_lat_d;
    end
  end

endmodule

// File: rtl/dram_rowbuf_lat_chk.sv
module dram_rowbuf_lat_chk #(
  parameter int ADDR_W  = 32,
  parameter int LAT_W   = 8,
  parameter int CNT_W   = 32,
  parameter int T_FIXED = 100,
  parameter int T_HIT   = 55
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_policy,
  input logic              resp_valid,
  input logic [LAT_W-1:0]  resp_lat,
  input logic [CNT_W-1:0]  rd_count,
  input logic [CNT_W-1:0]  wr_count,
  input logic [CNT_W-1:0]  rd_delay,
  input logic [CNT_W-1:0]  wr_delay
);

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  // R4
  fixed_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_policy == 2'b00 || req_policy == 2'b11)) |=> resp_lat == LAT_W'(T_FIXED));

  // R8
  close_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_policy == 2'b10) |=> resp_lat == LAT_W'(T_FIXED));

  // R5
  repeat_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_policy == 2'b01 && $past(req_valid) && $past(req_policy) == 2'b01
     && req_addr == $past(req_addr)) |=> resp_lat == LAT_W'(T_HIT));

  // R9
  rd_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (rd_count == $past(rd_count) + CNT_W'(1)) && $stable(wr_count));

  // R9
  rd_delay_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_delay == $past(rd_delay) + CNT_W'(resp_lat));

  // R10
  wr_delay_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (wr_delay == $past(wr_delay) + CNT_W'(resp_lat))
                                 && (wr_count == $past(wr_count) + CNT_W'(1)) && $stable(rd_delay));

  // R2
  idle_counters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rd_count) && $stable(wr_count) && $stable(rd_delay) && $stable(wr_delay));

endmodule

bind dram_rowbuf_lat dram_rowbuf_lat_chk #(
  .ADDR_W (ADDR_W),
  .LAT_W  (LAT_W),
  .CNT_W  (CNT_W),
  .T_FIXED(T_FIXED),
  .T_HIT  (T_CAS + T_BUS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_policy(req_policy),
  .resp_valid(resp_valid),
  .resp_lat  (resp_lat),
  .rd_count  (rd_count),
  .wr_count  (wr_count),
  .rd_delay  (rd_delay),
  .wr_delay  (wr_delay)
);

// File: tb/dram_rowbuf_lat_bench.sv
`timescale 1ns/1ps
module dram_rowbuf_lat_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [31:0] req_addr;
  logic [1:0]  req_policy;
  logic        resp_valid;
  logic [7:0]  resp_lat;
  logic [31:0] rd_count, wr_count, rd_delay, wr_delay;

  int n_chk;
  int n_fail;
  int cyc;

  // model state
  bit          mv [16];
  int unsigned mr [16];
  int unsigned e_rc, e_wc, e_rd, e_wd;

  dram_rowbuf_lat u_dram_rowbuf_lat (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_policy(req_policy),
    .resp_valid(resp_valid),
    .resp_lat  (resp_lat),
    .rd_count  (rd_count),
    .wr_count  (wr_count),
    .rd_delay  (rd_delay),
    .wr_delay  (wr_delay)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Computes expected latency and updates the model for one access.
  task automatic model_step(input logic [31:0] a, input logic wr, input logic [1:0] pol,
                            output int lat, output string tag);
    int unsigned bk = (a >> 6) & 32'hF;
    int unsigned rw = a >> 14;
    if (pol == 2'b01) begin
      if (!mv[bk])          begin lat = 100; tag = "R6"; end
      else if (mr[bk] == rw) begin lat = 55;  tag = "R5"; end
      else                  begin lat = 145; tag = "R7"; end
      mv[bk] = 1'b1;
      mr[bk] = rw;
    end else if (pol == 2'b10) begin
      lat = 100; tag = "R8";
      mv[bk] = 1'b0;
    end else begin
      lat = 100; tag = "R4";
    end
    if (wr) begin e_wc += 1; e_wd += lat; end
    else    begin e_rc += 1; e_rd += lat; end
  endtask

  task automatic chk_counters();
    chk(rd_count == e_rc, "R9", rd_count, e_rc);
    chk(rd_delay == e_rd, "R9", rd_delay, e_rd);
    chk(wr_count == e_wc, "R10", wr_count, e_wc);
    chk(wr_delay == e_wd, "R10", wr_delay, e_wd);
  endtask

  task automatic do_req(input logic [31:0] a, input logic wr, input logic [1:0] pol,
                        input string tag_ovr);
    int    lat;
    string tag;
    model_step(a, wr, pol, lat, tag);
    if (tag_ovr != "") tag = tag_ovr;
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_addr   = a;
    req_policy = pol;
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid == 1'b1, "R2", resp_valid, 1);
    chk(resp_lat == lat, tag, resp_lat, lat);
    chk_counters();
  endtask

  logic [31:0] seed;

  initial begin
    int    lat_a, lat_b;
    string tg_a, tg_b;
    n_chk = 0; n_fail = 0; cyc = 0;
    e_rc = 0; e_wc = 0; e_rd = 0; e_wd = 0;
    for (int i = 0; i < 16; i++) begin mv[i] = 1'b0; mr[i] = 0; end
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_policy = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(resp_valid == 1'b0, "R1", resp_valid, 0);
    chk(rd_count == 0 && wr_count == 0, "R1", rd_count + wr_count, 0);
    chk(rd_delay == 0 && wr_delay == 0, "R1", rd_delay + wr_delay, 0);

    // R3 / R11 address mapping and bank independence
    do_req((32'd1 << 14) | (32'd3 << 6), 1'b0, 2'b01, "R1");
    do_req((32'd1 << 14) | (32'd5 << 10) | (32'd3 << 6) | 32'd17, 1'b1, 2'b01, "R3");
    do_req((32'd2 << 14) | (32'd4 << 6), 1'b0, 2'b01, "R11");
    do_req((32'd1 << 14) | (32'd3 << 6) | 32'd40, 1'b0, 2'b01, "R11");
    do_req(32'd64 * 32'd19, 1'b1, 2'b01, "R3");
    do_req((32'd2 << 14) | (32'd9 << 10) | (32'd4 << 6), 1'b0, 2'b01, "R11");

    // R8 close leaves the bank empty
    do_req((32'd6 << 14) | (32'd3 << 6), 1'b0, 2'b10, "R8");
    do_req((32'd6 << 14) | (32'd3 << 6), 1'b1, 2'b01, "R8");

    // R4 fixed mode has no effect on any bank
    for (int b = 0; b < 16; b++) begin
      do_req((32'd9 << 14) | (32'(b) << 6), b[0], (b[1] ? 2'b11 : 2'b00), "R4");
    end
    for (int b = 0; b < 16; b++) begin
      do_req((32'd7 << 14) | (32'(b) << 6), 1'b0, 2'b01, "R4");
    end

    // R7 conflict then R5 hit on new row
    do_req((32'd8 << 14) | (32'd2 << 6), 1'b0, 2'b01, "R7");
    do_req((32'd8 << 14) | (32'd2 << 6), 1'b1, 2'b01, "R5");

    // R2 back-to-back: open row 11 in bank 12, then hit it next cycle
    model_step((32'd11 << 14) | (32'd12 << 6), 1'b0, 2'b01, lat_a, tg_a);
    model_step((32'd11 << 14) | (32'd12 << 6) | 32'd5, 1'b1, 2'b01, lat_b, tg_b);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_policy = 2'b01;
    req_addr = (32'd11 << 14) | (32'd12 << 6);
    @(negedge clk);
    req_write = 1'b1; req_addr = (32'd11 << 14) | (32'd12 << 6) | 32'd5;
    chk(resp_valid == 1'b1 && resp_lat == lat_a, "R2", resp_lat, lat_a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid == 1'b1 && resp_lat == lat_b, "R2", resp_lat, lat_b);
    chk_counters();
    @(negedge clk);
    chk(resp_valid == 1'b0, "R2", resp_valid, 0);

    // Mixed sweep over 4 rows x 16 banks x all policies
    seed = 32'h1234_5678;
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = (((seed >> 8) & 32'h3) << 14) | (((seed >> 12) & 32'hF) << 10)
        | (((seed >> 16) & 32'hF) << 6) | ((seed >> 24) & 32'h3F);
      do_req(a, seed[27], seed[30:29], "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule